// File: doc/BRIEF.md
# Front-End Readout Frame Parser

This block takes the 12-bit digitized output of an analog front-end readout chip, one sample per clock, and separates the frames it carries from the idle traffic around them. A programmable 12-bit threshold turns each sample into a digital level. The level is inverted with respect to the analog amplitude, so a sample below the threshold reads as a logic one. Between frames the chip emits isolated one-sample synchronization pulses. A frame opens with a run of three logic-one samples.

After a header the block decodes an 8-bit chip address and an error bit. It then gates the next 128 samples, one per analog channel, to its output with a valid strobe and a channel index. All other samples are suppressed, and the parsed data bus keeps its last value. The block is pipelined and accepts a new sample on every clock. A payload sample appears at the outputs two clocks after it is presented at the input.

The control FSM has four states. `PS_HUNT` searches for the header. `PS_ADDR` shifts in the address. `PS_FLAG` takes the error slot. `PS_DATA` forwards the payload. Its transitions are:
- HUNT→ADDR on the third consecutive logic one.
- ADDR→FLAG after eight address samples.
- FLAG→DATA unconditionally.
- DATA→HUNT after channel 127.

Top module: `fe_frame_parser`

## Requirements
- R1: A sample strictly below `thresh_i` reads as logic 1. A sample equal to or above `thresh_i` reads as logic 0.
- R2: Only three consecutive logic-1 samples start a frame. Isolated logic-1 pulses and pairs of logic-1 samples never start a frame and never assert `valid_o`.
- R3: The eight samples after the header form the address, most significant bit first, and this value appears on `addr_o`.
- R4: The logic level of the ninth sample after the header appears on `err_o`.
- R5: `addr_o` and `err_o` update on the clock edge one cycle before the first payload sample is presented. They stay stable until the next frame's update.
- R6: Exactly 128 samples follow the error slot. Each is presented on `data_o` with `valid_o` high, unchanged in value, two clocks after it entered `sample_i`.
- R7: `chan_o` is 0 on the first payload sample and increases by one on each following payload sample, up to 127.
- R8: Outside the payload `valid_o` is low and `data_o` holds the last payload value.
- R9: After channel 127 the block returns to header search. A header that starts on the very next sample is recognised, so back-to-back frames are supported.
- R10: A synchronous reset, even in mid-frame, returns the block to header search. It drives `valid_o`, `data_o`, `chan_o`, `addr_o` and `err_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 12 | Digitized stream sample |
| thresh_i | input | 12 | Digital level threshold |
| data_o | output | 12 | Parsed payload sample |
| valid_o | output | 1 | Payload sample qualifier |
| chan_o | output | 7 | Channel index of `data_o` |
| addr_o | output | 8 | Chip address of the current frame |
| err_o | output | 1 | Error bit of the current frame |

## Verification
The bench sends a sync stream that mixes single pulses with pairs of logic-one samples. A header detector that counts too few ones would open spurious frames here and assert `valid_o`.

One frame places its zero levels exactly at the threshold. An off-by-one comparator would read those samples as ones and corrupt the address.

Two frames are sent back to back with no gap. An FSM that lingered a cycle after channel 127 would miss the first header sample and lose the second frame.

A reset arrives in mid-payload. A design that kept the channel counter or the address across that reset would mislabel the next frame. Every cycle is also checked against the expected valid, data and channel, which catches a payload that is one sample short or shifted by a clock.

// File: rtl/fep_pkg.sv
package fep_pkg;

    typedef enum logic [1:0] {
        PS_HUNT = 2'd0,
        PS_ADDR = 2'd1,
        PS_FLAG = 2'd2,
        PS_DATA = 2'd3
    } fep_state_e;

endpackage

// File: rtl/fep_slicer.sv
// Input register stage: captures the sample and its digital level.
module fep_slicer #(
    parameter int DW     = 12,
    parameter bit INVERT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] sample_i,
    input  logic [DW-1:0] thresh_i,
    output logic [DW-1:0] s_data_o,
    output logic          s_bit_o
);

    logic lvl;

    generate
        if (INVERT) begin : g_inv
            // Digital high sits low on the analog scale.
            assign lvl = (sample_i < thresh_i);
        end else begin : g_dir
            assign lvl = (sample_i > thresh_i);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s_data_o <= '0;
            s_bit_o  <= 1'b0;
        end else begin
            s_data_o <= sample_i;
            s_bit_o  <= lvl;
        end
    end

endmodule

// File: rtl/fep_ctrl.sv
// Frame control FSM: header search, address, error slot, payload.
module fep_ctrl
    import fep_pkg::*;
#(
    parameter int HDR_LEN = 3,
    parameter int AW      = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_i,
    input  logic       chan_last_i,
    output fep_state_e state_o
);

    localparam int RW = (HDR_LEN > 1) ? $clog2(HDR_LEN) : 1;
    localparam int AB = (AW > 1) ? $clog2(AW) : 1;
    localparam logic [RW-1:0] RUN_LAST  = RW'(HDR_LEN - 1);
    localparam logic [AB-1:0] ADDR_LAST = AB'(AW - 1);

    fep_state_e state_q, state_d;
    logic [RW-1:0] run_q;
    logic [AB-1:0] acnt_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_HUNT: if (bit_i && run_q == RUN_LAST) state_d = PS_ADDR;
            PS_ADDR: if (acnt_q == ADDR_LAST)         state_d = PS_FLAG;
            PS_FLAG:                                  state_d = PS_DATA;
            PS_DATA: if (chan_last_i)                 state_d = PS_HUNT;
            default:                                  state_d = PS_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_HUNT;
        else     state_q <= state_d;
    end

    // Header run length and address bit position
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            acnt_q <= '0;
        end else begin
            if (state_q != PS_HUNT || !bit_i || run_q == RUN_LAST)
                run_q <= '0;
            else
                run_q <= run_q + 1'b1;

            if (state_q != PS_ADDR || acnt_q == ADDR_LAST)
                acnt_q <= '0;
            else
                acnt_q <= acnt_q + 1'b1;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/fep_chan_counter.sv
// Payload channel counter, wraps to zero after the last channel.
module fep_chan_counter #(
    parameter int NCH = 128,
    parameter int CW  = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc_i,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);

    localparam logic [CW-1:0] CNT_LAST = CW'(NCH - 1);

    assign last_o = inc_i && (cnt_o == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst)         cnt_o <= '0;
        else if (last_o) cnt_o <= '0;
        else if (inc_i)  cnt_o <= cnt_o + 1'b1;
    end

endmodule

// File: rtl/fep_data_reg.sv
// Output registers: address shifter, frame fields, payload data.
module fep_data_reg
    import fep_pkg::*;
#(
    parameter int DW = 12,
    parameter int AW = 8,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] s_data_i,
    input  logic          s_bit_i,
    input  fep_state_e    state_i,
    input  logic [CW-1:0] cnt_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o,
    output logic [CW-1:0] chan_o,
    output logic [AW-1:0] addr_o,
    output logic          err_o
);

    logic [AW-1:0] addr_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_sr <= '0;
            addr_o  <= '0;
            err_o   <= 1'b0;
            data_o  <= '0;
            chan_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            unique case (state_i)
                PS_ADDR: addr_sr <= {addr_sr[AW-2:0], s_bit_i};
                PS_FLAG: begin
                    addr_o <= addr_sr;
                    err_o  <= s_bit_i;
                end
                PS_DATA: begin
                    data_o  <= s_data_i;
                    chan_o  <= cnt_i;
                    valid_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fe_frame_parser.sv
module fe_frame_parser
    import fep_pkg::*;
#(
    parameter int DW      = 12,
    parameter int AW      = 8,
    parameter int NCH     = 128,
    parameter int HDR_LEN = 3,
    parameter bit INVERT  = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [DW-1:0]          sample_i,
    input  logic [DW-1:0]          thresh_i,
    output logic [DW-1:0]          data_o,
    output logic                   valid_o,
    output logic [$clog2(NCH)-1:0] chan_o,
    output logic [AW-1:0]          addr_o,
    output logic                   err_o
);

    localparam int CW = $clog2(NCH);

    logic [DW-1:0] s_data;
    logic          s_bit;
    fep_state_e    state;
    logic [CW-1:0] cnt;
    logic          cnt_last;
    logic          in_data;

    assign in_data = (state == PS_DATA);

    fep_slicer #(.DW(DW), .INVERT(INVERT)) u_slicer (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_i),
        .thresh_i (thresh_i),
        .s_data_o (s_data),
        .s_bit_o  (s_bit)
    );

    fep_ctrl #(.HDR_LEN(HDR_LEN), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .bit_i       (s_bit),
        .chan_last_i (cnt_last),
        .state_o     (state)
    );

    fep_chan_counter #(.NCH(NCH), .CW(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .inc_i  (in_data),
        .cnt_o  (cnt),
        .last_o (cnt_last)
    );

    fep_data_reg #(.DW(DW), .AW(AW), .CW(CW)) u_out (
        .clk      (clk),
        .rst      (rst),
        .s_data_i (s_data),
        .s_bit_i  (s_bit),
        .state_i  (state),
        .cnt_i    (cnt),
        .data_o   (data_o),
        .valid_o  (valid_o),
        .chan_o   (chan_o),
        .addr_o   (addr_o),
        .err_o    (err_o)
    );

endmodule

// File: rtl/fep_checker.sv
module fep_checker #(
    parameter int DW  = 12,
    parameter int AW  = 8,
    parameter int NCH = 128
) (
    input logic                   clk,
    input logic                   rst,
    input logic [DW-1:0]          data_o,
    input logic                   valid_o,
    input logic [$clog2(NCH)-1:0] chan_o,
    input logic [AW-1:0]          addr_o,
    input logic                   err_o
);

    localparam int CW = $clog2(NCH);
    localparam int VL = $clog2(NCH + 1);

    logic          armed;
    logic          rst_d;
    logic [VL-1:0] vlen;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            armed <= 1'b0;
            vlen  <= '0;
        end else begin
            armed <= 1'b1;
            vlen  <= valid_o ? vlen + 1'b1 : '0;
        end
    end

    // R8: data bus holds outside the payload
    a_r8_hold_data: assert property (@(posedge clk) disable iff (rst)
        armed && !valid_o |-> $stable(data_o));

    // R7: first payload sample carries channel 0
    a_r7_first_chan: assert property (@(posedge clk) disable iff (rst)
        armed && $rose(valid_o) |-> chan_o == '0);

    // R7: channel advances by one per payload sample
    a_r7_chan_step: assert property (@(posedge clk) disable iff (rst)
        armed && valid_o && $past(valid_o) |-> chan_o == CW'($past(chan_o) + 1'b1));

    // R5: frame fields stay put during the payload
    a_r5_fields_stable: assert property (@(posedge clk) disable iff (rst)
        armed && valid_o |-> $stable(addr_o) && $stable(err_o));

    // R6: every payload burst is exactly NCH samples long
    a_r6_burst_len: assert property (@(posedge clk) disable iff (rst)
        armed && $fell(valid_o) |-> vlen == VL'(NCH));

    // R10: reset clears the qualifier
    a_r10_reset_valid: assert property (@(posedge clk)
        rst_d |-> !valid_o);

endmodule

bind fe_frame_parser fep_checker #(.DW(DW), .AW(AW), .NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .data_o  (data_o),
    .valid_o (valid_o),
    .chan_o  (chan_o),
    .addr_o  (addr_o),
    .err_o   (err_o)
);

// File: tb/sim_fe_frame_parser.sv
module sim_fe_frame_parser;

    localparam int NCH   = 128;
    localparam int EXP_N = 8192;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] din;
    logic [11:0] thr;
    logic [11:0] data_o;
    logic        valid_o;
    logic [6:0]  chan_o;
    logic [7:0]  addr_o;
    logic        err_o;

    always #5 clk = ~clk;

    fe_frame_parser u0 (
        .clk(clk), .rst(rst), .sample_i(din), .thresh_i(thr),
        .data_o(data_o), .valid_o(valid_o), .chan_o(chan_o),
        .addr_o(addr_o), .err_o(err_o)
    );

    int edge_n = 0;
    always @(posedge clk) edge_n <= edge_n + 1;

    bit          ev [EXP_N];
    logic [11:0] ed [EXP_N];
    logic [6:0]  ec [EXP_N];
    bit          au [EXP_N];
    logic [7:0]  ea [EXP_N];
    bit          ee [EXP_N];

    int          n_chk = 0, n_fail = 0, n_valid = 0;
    bit          mon_en = 1'b0, done = 1'b0;
    logic [11:0] hold_d = '0;
    logic [11:0] hi_lvl, lo_lvl;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Per-cycle comparison against the scheduled expectations
    always @(negedge clk) begin
        if (valid_o === 1'b1) n_valid++;
        if (mon_en && !rst && edge_n < EXP_N) begin
            chk(valid_o === ev[edge_n], "R8", "valid", int'(valid_o), int'(ev[edge_n]));
            if (ev[edge_n]) begin
                chk(data_o === ed[edge_n], "R6", "payload data", int'(data_o), int'(ed[edge_n]));
                chk(chan_o === ec[edge_n], "R7", "channel", int'(chan_o), int'(ec[edge_n]));
                chk(addr_o === ea[edge_n], "R5", "addr during payload", int'(addr_o), int'(ea[edge_n]));
                hold_d = ed[edge_n];
            end else begin
                chk(data_o === hold_d, "R8", "held data", int'(data_o), int'(hold_d));
            end
            if (au[edge_n]) begin
                chk(addr_o === ea[edge_n], "R3", "addr before payload", int'(addr_o), int'(ea[edge_n]));
                chk(err_o === ee[edge_n], "R4", "err before payload", int'(err_o), int'(ee[edge_n]));
            end
        end
    end

    // Drive one sample; oi is the edge whose outputs reflect it
    task automatic put(input logic [11:0] x, output int oi);
        @(negedge clk);
        din = x;
        oi  = edge_n + 2;
    endtask

    task automatic idle(input int n);
        int oi;
        for (int i = 0; i < n; i++) put(lo_lvl, oi);
    endtask

    task automatic send_frame(input logic [7:0] a, input bit e, input int seed, input int npay);
        int oi;
        logic [11:0] x;
        for (int i = 0; i < 3; i++) put(hi_lvl, oi);
        for (int i = 7; i >= 0; i--) put(a[i] ? hi_lvl : lo_lvl, oi);
        put(e ? hi_lvl : lo_lvl, oi);
        au[oi] = 1'b1; ea[oi] = a; ee[oi] = e;
        for (int j = 0; j < npay; j++) begin
            x = 12'((seed + j * 37) % 4096);
            put(x, oi);
            ev[oi] = 1'b1; ed[oi] = x; ec[oi] = 7'(j); ea[oi] = a; ee[oi] = e;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        mon_en = 1'b0;
        rst = 1'b1;
        din = lo_lvl;
        repeat (3) @(negedge clk);
        for (int i = 0; i < EXP_N; i++) begin
            ev[i] = 1'b0; au[i] = 1'b0;
        end
        hold_d = '0;
        chk(valid_o == 1'b0, "R10", "valid after reset", int'(valid_o), 0);
        chk(data_o == '0,    "R10", "data after reset",  int'(data_o), 0);
        chk(chan_o == '0,    "R10", "chan after reset",  int'(chan_o), 0);
        chk(addr_o == '0,    "R10", "addr after reset",  int'(addr_o), 0);
        chk(err_o == 1'b0,   "R10", "err after reset",   int'(err_o), 0);
        rst = 1'b0;
        mon_en = 1'b1;
    endtask

    task automatic t_sync_only();
        int oi;
        int v0 = n_valid;
        for (int k = 0; k < 20; k++) begin
            idle(5);
            put(hi_lvl, oi);
            idle(4);
            put(hi_lvl, oi);
            put(hi_lvl, oi);
        end
        idle(4);
        chk(n_valid == v0, "R2", "valid count during sync pulses", n_valid - v0, 0);
        chk(data_o == hold_d, "R8", "data held after sync", int'(data_o), int'(hold_d));
    endtask

    task automatic t_basic();
        send_frame(8'hA5, 1'b0, 11, NCH);
        idle(6);
        chk(addr_o == 8'hA5, "R3", "addr after frame", int'(addr_o), 8'hA5);
        send_frame(8'h3C, 1'b1, 900, NCH);
        idle(6);
        chk(err_o == 1'b1, "R4", "err after frame", int'(err_o), 1);
        chk(data_o == hold_d, "R8", "data held after frame", int'(data_o), int'(hold_d));
    endtask

    task automatic t_threshold_edge();
        thr = 12'd3000; hi_lvl = 12'd2999; lo_lvl = 12'd3000;
        idle(4);
        send_frame(8'h81, 1'b0, 2000, NCH);
        idle(4);
        chk(addr_o == 8'h81, "R1", "addr with levels at threshold", int'(addr_o), 8'h81);
        chk(err_o == 1'b0, "R1", "err slot equal to threshold", int'(err_o), 0);
        thr = 12'd2000; hi_lvl = 12'd1500; lo_lvl = 12'd2300;
        idle(4);
    endtask

    task automatic t_back_to_back();
        send_frame(8'h5A, 1'b1, 77, NCH);
        send_frame(8'hF0, 1'b0, 3000, NCH);
        idle(4);
        chk(addr_o == 8'hF0, "R9", "second back-to-back addr", int'(addr_o), 8'hF0);
        chk(err_o == 1'b0, "R9", "second back-to-back err", int'(err_o), 0);
    endtask

    task automatic t_mid_reset();
        send_frame(8'h77, 1'b1, 500, 40);
        do_reset();
        idle(3);
        send_frame(8'h12, 1'b0, 1234, NCH);
        idle(4);
        chk(addr_o == 8'h12, "R10", "addr of frame after mid reset", int'(addr_o), 8'h12);
    endtask

    initial begin
        thr = 12'd2000; hi_lvl = 12'd1500; lo_lvl = 12'd2300;
        din = lo_lvl;
        rst = 1'b1;
        do_reset();
        idle(5);
        t_sync_only();
        t_basic();
        t_threshold_edge();
        t_back_to_back();
        t_mid_reset();
        t_sync_only();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run incomplete actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule